// File: doc/BRIEF.md
# Byte SEC-DED Hamming Codec

This block guards one byte with a single-error-correcting, double-error-detecting Hamming code. The encoder half turns a byte into a 13-bit protected word: twelve Hamming positions, four of them check bits at the power-of-two positions, plus one overall parity bit. Each check bit covers the positions whose binary index has that bit set. The check bits can therefore be recomputed over the stored word, and a nonzero syndrome names the failing position directly.

The decoder half takes a 13-bit word read back from storage. It recomputes the 4-bit syndrome and the overall parity, and sorts the word into one of five error kinds: none, single, parity-bit-only, double, and out-of-range. It returns the byte, corrected where that is possible, together with a "fixed" flag and an "uncorrectable" flag. Both halves are combinational. The parameter `REG_OUT` places a register stage in front of every output. The stage resets to zero and adds one cycle of latency.

Top module: `secded_codec`

## Requirements
- R1: In the protected word, bit index p-1 holds Hamming position p for p = 1..12. Check bits sit at positions 1, 2, 4 and 8. Data bits `enc_data_i[0]`..`enc_data_i[7]` sit at positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order.
- R2: Call the data bits d1..d8 (`enc_data_i[0]`..`[7]`). The check bits are: position 1 = d1^d2^d4^d5^d7, position 2 = d1^d3^d4^d6^d7, position 4 = d2^d3^d4^d8, and position 8 = d5^d6^d7^d8.
- R3: Bit index 12 (position 13) makes the parity even over positions 1..12, so every encoded word has an even number of ones.
- R4: For an error-free word, the syndrome is 0, both flags are low, and the output byte equals the data field.
- R5: When exactly one of positions 1..12 is flipped, `dec_syn_o` equals that position, `dec_fixed_o` is high, `dec_fatal_o` is low, and the original byte is returned.
- R6: When only position 13 is flipped, the syndrome is 0, `dec_fixed_o` is high, and the byte is returned unchanged.
- R7: When any two positions are flipped, `dec_fatal_o` is high and `dec_fixed_o` is low. The output byte is the uncorrected data field, and the syndrome is the XOR of the two position numbers, where position 13 counts as 0.
- R8: A syndrome of 13, 14 or 15 with odd overall parity raises `dec_fatal_o` only, and the data field passes through uncorrected.
- R9: `dec_fixed_o` and `dec_fatal_o` are never high together.
- R10: With `REG_OUT`=1, every output shows the result for the inputs present at the previous rising clock edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 8 | Byte to protect |
| enc_word_o | output | 13 | Protected word |
| dec_word_i | input | 13 | Stored word to check |
| dec_data_o | output | 8 | Recovered byte |
| dec_syn_o | output | 4 | Syndrome |
| dec_fixed_o | output | 1 | Single error found and repaired |
| dec_fatal_o | output | 1 | Uncorrectable error |

## Verification
The block holds no state beyond the optional output stage, so any fault in the classification shows at the ports in the very cycle its input is presented, one edge later when registered. A wrong coverage mask shows up as a syndrome that does not match the flipped position, or as a check-bit mismatch, on the first single-bit-flip or encode pattern that touches that position. A misordered kind decision shows up as a wrong flag pair on the first double or parity-only error. A broken output stage shows up as a stale or early value within one clock.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;
    localparam int DATA_W = 8;
    localparam int CHK_W  = 4;
    localparam int HAM_W  = 12;
    localparam int WORD_W = HAM_W + 1;

    typedef logic [HAM_W:1]    ham_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CHK_W-1:0]  syn_t;

    typedef enum logic [2:0] {
        ERR_NONE,
        ERR_SINGLE,
        ERR_PARITY,
        ERR_DOUBLE,
        ERR_RANGE
    } err_kind_t;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // positions whose index has bit k set
    function automatic ham_t cover_mask(int k);
        ham_t m;
        m = '0;
        for (int p = 1; p <= HAM_W; p++)
            m[p] = ((p >> k) & 1) == 1;
        return m;
    endfunction

    function automatic ham_t place_data(byte_t d);
        ham_t h;
        int   k;
        h = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                h[p] = d[k];
                k++;
            end
        end
        return h;
    endfunction

    function automatic byte_t pick_data(ham_t h);
        byte_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p <= HAM_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = h[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic syn_t calc_syn(ham_t h);
        syn_t s;
        s = '0;
        for (int p = 1; p <= HAM_W; p++)
            if (h[p]) s = s ^ syn_t'(p);
        return s;
    endfunction
endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc
    import secded_pkg::*;
(
    input  byte_t              data_i,
    output logic [WORD_W-1:0]  word_o
);
    ham_t             placed;
    ham_t             full;
    logic [CHK_W-1:0] chk;

    assign placed = place_data(data_i);

    for (genvar k = 0; k < CHK_W; k++) begin : g_chk
        assign chk[k] = ^(placed & cover_mask(k));
    end

    always_comb begin
        full = placed;
        for (int k = 0; k < CHK_W; k++)
            full[1 << k] = chk[k];
    end

    assign word_o = {^full, full};
endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec
    import secded_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output byte_t             data_o,
    output syn_t              syn_o,
    output logic              fixed_o,
    output logic              fatal_o
);
    ham_t      h;
    ham_t      repaired;
    syn_t      syn;
    logic      par_bad;
    err_kind_t kind;

    assign h       = word_i[HAM_W-1:0];
    assign syn     = calc_syn(h);
    assign par_bad = ^word_i;

    always_comb begin
        if (syn == '0)
            kind = par_bad ? ERR_PARITY : ERR_NONE;
        else if (!par_bad)
            kind = ERR_DOUBLE;
        else if (syn <= syn_t'(HAM_W))
            kind = ERR_SINGLE;
        else
            kind = ERR_RANGE;
    end

    always_comb begin
        repaired = h;
        fixed_o  = 1'b0;
        fatal_o  = 1'b0;
        unique case (kind)
            ERR_NONE:   ;
            ERR_SINGLE: begin
                repaired = h ^ (ham_t'(1) << (syn - 1'b1));
                fixed_o  = 1'b1;
            end
            ERR_PARITY: fixed_o = 1'b1;
            ERR_DOUBLE: fatal_o = 1'b1;
            ERR_RANGE:  fatal_o = 1'b1;
            default:    fatal_o = 1'b1;
        endcase
    end

    assign data_o = pick_data(repaired);
    assign syn_o  = syn;
endmodule

// File: rtl/secded_stage.sv
`timescale 1ns/1ps
module secded_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
        end
    end else begin : g_wire
        assign q_o = d_i;
    end
endmodule

// File: rtl/secded_codec.sv
`timescale 1ns/1ps
module secded_codec
    import secded_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        enc_data_i,
    output logic [12:0]       enc_word_o,
    input  logic [12:0]       dec_word_i,
    output logic [7:0]        dec_data_o,
    output logic [3:0]        dec_syn_o,
    output logic              dec_fixed_o,
    output logic              dec_fatal_o
);
    localparam int DEC_W = DATA_W + CHK_W + 2;

    logic [WORD_W-1:0] enc_word_c;
    byte_t             dec_data_c;
    syn_t              dec_syn_c;
    logic              dec_fixed_c;
    logic              dec_fatal_c;
    logic [DEC_W-1:0]  dec_bundle_q;

    secded_enc u_enc (
        .data_i (enc_data_i),
        .word_o (enc_word_c)
    );

    secded_dec u_dec (
        .word_i  (dec_word_i),
        .data_o  (dec_data_c),
        .syn_o   (dec_syn_c),
        .fixed_o (dec_fixed_c),
        .fatal_o (dec_fatal_c)
    );

    secded_stage #(.W(WORD_W), .REG_OUT(REG_OUT)) u_enc_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (enc_word_c),
        .q_o   (enc_word_o)
    );

    secded_stage #(.W(DEC_W), .REG_OUT(REG_OUT)) u_dec_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dec_data_c, dec_syn_c, dec_fixed_c, dec_fatal_c}),
        .q_o   (dec_bundle_q)
    );

    assign {dec_data_o, dec_syn_o, dec_fixed_o, dec_fatal_o} = dec_bundle_q;
endmodule

// File: rtl/secded_codec_chk.sv
`timescale 1ns/1ps
module secded_codec_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  enc_data,
    input logic [12:0] enc_word,
    input logic [12:0] dec_word,
    input logic [7:0]  dec_data,
    input logic [3:0]  dec_syn,
    input logic        dec_fixed,
    input logic        dec_fatal,
    input logic [12:0] enc_word_q,
    input logic [7:0]  dec_data_q,
    input logic        dec_fixed_q,
    input logic        dec_fatal_q
);
    logic [7:0] enc_field;
    logic [7:0] dec_field;
    logic       dec_odd;

    assign enc_field = {enc_word[11:8], enc_word[6:4], enc_word[2]};
    assign dec_field = {dec_word[11:8], dec_word[6:4], dec_word[2]};
    assign dec_odd   = ^dec_word;

    // R1
    enc_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_field == enc_data);

    // R3
    enc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (^enc_word) == 1'b0);

    // R4
    clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_odd && dec_syn == 4'd0) |-> (!dec_fixed && !dec_fatal && dec_data == dec_field));

    // R5
    single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_odd && dec_syn != 4'd0 && dec_syn <= 4'd12) |-> (dec_fixed && !dec_fatal));

    // R6
    parbit_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_odd && dec_syn == 4'd0) |-> (dec_fixed && dec_data == dec_field));

    // R7
    double_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_odd && dec_syn != 4'd0) |-> (dec_fatal && dec_data == dec_field));

    // R8
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_odd && dec_syn > 4'd12) |-> (dec_fatal && !dec_fixed && dec_data == dec_field));

    // R9
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_fixed_q && dec_fatal_q));

    if (REG_OUT) begin : g_stage_chk
        logic armed;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) armed <= 1'b0;
            else        armed <= 1'b1;
        end

        // R10
        enc_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> enc_word_q == $past(enc_word));

        // R10
        dec_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> (dec_data_q == $past(dec_data) && dec_fatal_q == $past(dec_fatal)));
    end
endmodule

bind secded_codec secded_codec_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enc_data    (enc_data_i),
    .enc_word    (enc_word_c),
    .dec_word    (dec_word_i),
    .dec_data    (dec_data_c),
    .dec_syn     (dec_syn_c),
    .dec_fixed   (dec_fixed_c),
    .dec_fatal   (dec_fatal_c),
    .enc_word_q  (enc_word_o),
    .dec_data_q  (dec_data_o),
    .dec_fixed_q (dec_fixed_o),
    .dec_fatal_q (dec_fatal_o)
);

// File: tb/test_secded_codec.sv
`timescale 1ns/1ps
module test_secded_codec;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  enc_d = '0;
    logic [12:0] dec_w = '0;
    logic [12:0] enc_word_o;
    logic [7:0]  dec_data_o;
    logic [3:0]  dec_syn_o;
    logic        dec_fixed_o;
    logic        dec_fatal_o;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    secded_codec i_secded_codec (
        .clk         (clk),
        .rst_n       (rst_n),
        .enc_data_i  (enc_d),
        .enc_word_o  (enc_word_o),
        .dec_word_i  (dec_w),
        .dec_data_o  (dec_data_o),
        .dec_syn_o   (dec_syn_o),
        .dec_fixed_o (dec_fixed_o),
        .dec_fatal_o (dec_fatal_o)
    );

    function automatic logic [12:0] ref_enc(logic [7:0] d);
        logic [12:0] w;
        w[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        w[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        w[2]  = d[0];
        w[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
        w[4]  = d[1];
        w[5]  = d[2];
        w[6]  = d[3];
        w[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
        w[8]  = d[4];
        w[9]  = d[5];
        w[10] = d[6];
        w[11] = d[7];
        w[12] = ^w[11:0];
        return w;
    endfunction

    function automatic logic [7:0] field(logic [12:0] w);
        return {w[11:8], w[6:4], w[2]};
    endfunction

    function automatic logic [3:0] pnum(int p);
        return (p == 13) ? 4'd0 : 4'(p);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [7:0] d, logic [12:0] w);
        @(negedge clk);
        enc_d = d;
        dec_w = w;
        @(negedge clk);
    endtask

    task automatic t_reset;
        enc_d = 8'hFF;
        dec_w = 13'h1FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 reset enc", 16'(enc_word_o), 16'h0);
        chk("R10 reset dec", {4'h0, dec_data_o, dec_syn_o}, 16'h0);
        chk("R10 reset flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_encode;
        logic [7:0] vec [6] = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80};
        foreach (vec[i]) begin
            apply(vec[i], '0);
            chk("R1 R2 R3 encode", 16'(enc_word_o), 16'(ref_enc(vec[i])));
        end
    endtask

    task automatic t_clean;
        for (int b = 0; b < 256; b++) begin
            apply(8'(b), ref_enc(8'(b)));
            chk("R4 clean data", {4'h0, dec_data_o, dec_syn_o}, {4'h0, 8'(b), 4'h0});
            chk("R4 clean flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h0);
        end
    endtask

    task automatic t_single;
        logic [7:0] vec [4] = '{8'h00, 8'hFF, 8'h5A, 8'h81};
        foreach (vec[i]) begin
            for (int p = 1; p <= 12; p++) begin
                apply(vec[i], ref_enc(vec[i]) ^ (13'd1 << (p - 1)));
                chk("R5 single data+syn", {4'h0, dec_data_o, dec_syn_o}, {4'h0, vec[i], 4'(p)});
                chk("R5 single flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h2);
            end
        end
    endtask

    task automatic t_parbit;
        apply(8'h96, ref_enc(8'h96) ^ 13'h1000);
        chk("R6 parity bit data+syn", {4'h0, dec_data_o, dec_syn_o}, {4'h0, 8'h96, 4'h0});
        chk("R6 parity bit flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h2);
    endtask

    task automatic t_double;
        logic [12:0] w;
        for (int p = 1; p <= 13; p++) begin
            for (int q = p + 1; q <= 13; q++) begin
                w = ref_enc(8'hC3) ^ (13'd1 << (p - 1)) ^ (13'd1 << (q - 1));
                apply(8'h00, w);
                chk("R7 double data+syn", {4'h0, dec_data_o, dec_syn_o},
                    {4'h0, field(w), pnum(p) ^ pnum(q)});
                chk("R7 R9 double flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h1);
            end
        end
    endtask

    task automatic t_range;
        logic [12:0] w;
        w = ref_enc(8'h3C) ^ 13'b0100000000011;   // positions 1,2,12 -> 15
        apply(8'h00, w);
        chk("R8 range 15", {4'h0, dec_data_o, dec_syn_o}, {4'h0, field(w), 4'd15});
        chk("R8 range 15 flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h1);
        w = ref_enc(8'h3C) ^ 13'b0000010001001;   // positions 1,4,8 -> 13
        apply(8'h00, w);
        chk("R8 range 13", {4'h0, dec_data_o, dec_syn_o}, {4'h0, field(w), 4'd13});
        chk("R8 range 13 flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h1);
        w = ref_enc(8'hE7) ^ 13'b0000010001010;   // positions 2,4,8 -> 14
        apply(8'h00, w);
        chk("R8 range 14", {4'h0, dec_data_o, dec_syn_o}, {4'h0, field(w), 4'd14});
        chk("R8 R9 range 14 flags", {14'h0, dec_fixed_o, dec_fatal_o}, 16'h1);
    endtask

    task automatic t_latency;
        apply(8'h11, ref_enc(8'h11));
        enc_d = 8'h22;
        dec_w = ref_enc(8'h22) ^ 13'h0020;
        #1;
        chk("R10 hold enc", 16'(enc_word_o), 16'(ref_enc(8'h11)));
        chk("R10 hold dec", {4'h0, dec_data_o, dec_syn_o}, {4'h0, 8'h11, 4'h0});
        @(negedge clk);
        chk("R10 update enc", 16'(enc_word_o), 16'(ref_enc(8'h22)));
        chk("R10 update dec", {4'h0, dec_data_o, dec_syn_o}, {4'h0, 8'h22, 4'd6});
    endtask

    initial begin
        t_reset();
        t_encode();
        t_clean();
        t_single();
        t_parbit();
        t_double();
        t_range();
        t_latency();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule